// File: doc/BRIEF.md
# Deferred Instruction RAM Updater

This block holds the instruction memory of a free-running microcode sequencer and gives a host a way to read and write it. The sequencer's program counter advances by one address every clock and wraps, so each word is fetched once per pass. A host access is taken into a single pending-access register. What happens next depends on a bus-mode bit.

In direct mode the pending access runs on the very next cycle. It takes the memory address bus away from the program counter for that cycle, so the fetch stream shows a jump. In deferred mode the access waits until the program counter itself reaches the target address, and runs in that slot. The instruction stream is therefore never disturbed. A deferred access can take up to one full pass of the counter. The host must space its deferred requests by at least one pass and must wait for the busy flag to fall before it uses read data.

A request that arrives while an access is still pending is discarded and sets a sticky error flag.

Top module: `instr_ram_updater`

## Requirements
- R1: The bus-mode bit resets to 1 (direct; 0 means deferred). A write through `mode_we_i` shows on `direct_mode_o` in the next cycle.
- R2: After reset, `busy_o`, `err_o` and `rd_valid_o` are 0, `fetch_addr_o` is 0, and every memory word reads as zero.
- R3: With no direct access under way, `fetch_addr_o` equals the program counter. The counter steps by one every cycle and wraps from the last address to 0.
- R4: A request (`req_valid_i` high while `busy_o` is low) sets `busy_o` in the next cycle. The pending register captures the address, the write data and the direction (`req_write_i` = 1 for a write).
- R5: In direct mode, a pending access runs in the first cycle it is pending. `fetch_addr_o` then shows the requested address, and `busy_o` is low in the following cycle.
- R6: In deferred mode, a pending access runs in the first pending cycle in which the program counter equals the requested address. `fetch_addr_o` always shows the program counter.
- R7: In a deferred write, the fetch in the matching slot still returns the old word. The new word is fetched from the next pass on.
- R8: After a read access, `rd_valid_o` is high for exactly one cycle (the cycle after the access), with `rd_data_o` holding the word read. `rd_data_o` keeps that value until the next read.
- R9: A request while `busy_o` is high is dropped and the pending access is unchanged. `err_o` then goes high and stays high until reset.
- R10: A deferred access leaves `busy_o` high for at most DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load the bus-mode bit |
| mode_i | input | 1 | New bus-mode value (1 direct, 0 deferred) |
| req_valid_i | input | 1 | Host access request |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W | Target instruction address |
| req_wdata_i | input | DATA_W | Write data |
| direct_mode_o | output | 1 | Current bus-mode bit |
| busy_o | output | 1 | Access pending |
| err_o | output | 1 | Sticky dropped-request flag |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DATA_W | Last read word |
| fetch_addr_o | output | ADDR_W | Address on the instruction memory bus |
| fetch_instr_o | output | DATA_W | Word fetched for the sequencer |

## Verification
A pending register that captured the wrong address or direction shows up as a bad word or a missing read pulse. This surfaces within one counter pass, at the latest when the counter reaches the target. A wrong match condition or mode decode is visible in the same cycle: `fetch_addr_o` leaves the counter sequence, or `busy_o` stays high past the expected slot. A write that lands a cycle early is seen when `fetch_instr_o` shows the new word in the matching slot itself.

// File: rtl/iru_pkg.sv
package iru_pkg;
  typedef enum logic {
    MODE_DEFERRED = 1'b0,
    MODE_DIRECT   = 1'b1
  } bus_mode_e;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/iru_pc_counter.sv
module iru_pc_counter #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + ADDR_W'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/iru_pending.sv
module iru_pending
  import iru_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  bus_mode_e         mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              exec_o,
  output acc_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              busy_q, err_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              slot_hit, exec, accept;

  assign slot_hit = (pc_i == addr_q);
  assign exec     = busy_q && ((mode_i == MODE_DIRECT) || slot_hit);
  assign accept   = req_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      kind_q  <= ACC_READ;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (accept) begin
        busy_q  <= 1'b1;
        kind_q  <= req_write_i ? ACC_WRITE : ACC_READ;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end else if (exec) begin
        busy_q  <= 1'b0;
      end
      // a request during a pending access is discarded
      if (req_valid_i && busy_q) err_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign err_o   = err_q;
  assign exec_o  = exec;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/iru_imem.sv
module iru_imem #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read before write: slot fetch sees the old word
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/instr_ram_updater.sv
module instr_ram_updater
  import iru_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              mode_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              direct_mode_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [DATA_W-1:0] fetch_instr_o
);
  bus_mode_e         mode_q;
  logic [ADDR_W-1:0] pc;
  logic              exec;
  acc_kind_e         kind;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_rdata;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_DIRECT;
    else if (mode_we_i) mode_q <= bus_mode_e'(mode_i);
  end

  iru_pc_counter #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pc_o  (pc)
  );

  iru_pending #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .mode_i     (mode_q),
    .pc_i       (pc),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .exec_o     (exec),
    .kind_o     (kind),
    .addr_o     (pend_addr),
    .wdata_o    (pend_wdata)
  );

  // host steals the bus only while its access runs
  assign bus_addr = exec ? pend_addr : pc;

  iru_imem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(bus_addr),
    .rdata_o(bus_rdata),
    .we_i   (exec && (kind == ACC_WRITE)),
    .waddr_i(pend_addr),
    .wdata_i(pend_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= exec && (kind == ACC_READ);
      if (exec && (kind == ACC_READ)) rd_data_q <= bus_rdata;
    end
  end

  assign direct_mode_o = (mode_q == MODE_DIRECT);
  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rd_data_q;
  assign fetch_addr_o  = bus_addr;
  assign fetch_instr_o = bus_rdata;
endmodule

// File: rtl/iru_checker.sv
module iru_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic              req_valid_i,
  input logic              direct_mode_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [ADDR_W-1:0] pc_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] wait_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wait_q <= '0;
    else if (busy_o) wait_q <= wait_q + 1'b1;
    else             wait_q <= '0;
  end

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(direct_mode_o));

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_i == ADDR_W'($past(pc_i) + ADDR_W'(1)));

  p_busy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  p_direct_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && direct_mode_o) |=> !busy_o);

  p_deferred_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !direct_mode_o |-> fetch_addr_o == pc_i);

  p_rd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!busy_o && $past(busy_o)));

  p_drop_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> err_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_wait_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> wait_q < (ADDR_W+1)'(DEPTH));
endmodule

bind instr_ram_updater iru_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_we_i    (mode_we_i),
  .req_valid_i  (req_valid_i),
  .direct_mode_o(direct_mode_o),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .rd_valid_o   (rd_valid_o),
  .fetch_addr_o (fetch_addr_o),
  .pc_i         (pc)
);

// File: tb/sim_instr_ram_updater.sv
`timescale 1ns/1ps
module sim_instr_ram_updater;
  localparam int AW = 6;
  localparam int DW = 24;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_we_i = 1'b0, mode_i = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic direct_mode_o, busy_o, err_o, rd_valid_o;
  logic [DW-1:0] rd_data_o, fetch_instr_o;
  logic [AW-1:0] fetch_addr_o;

  always #4 clk_i = ~clk_i;

  instr_ram_updater #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  int m_pc, m_paddr;
  bit m_mode, m_busy, m_err, m_pwr, m_rdv;
  logic [DW-1:0] m_pdata, m_rdd;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic bit m_exec();
    return m_busy && (m_mode || (m_pc == m_paddr));
  endfunction
  function automatic int m_faddr();
    return m_exec() ? m_paddr : m_pc;
  endfunction

  task automatic model_step();
    bit ex = m_exec();
    int fa = m_faddr();
    bit nbusy = m_busy;
    m_rdv = ex && !m_pwr;
    if (ex && !m_pwr) m_rdd = m_mem[fa];
    if (ex && m_pwr) m_mem[m_paddr] = m_pdata;
    if (ex) nbusy = 0;
    if (req_valid_i && m_busy) m_err = 1;
    if (req_valid_i && !m_busy) begin
      nbusy = 1; m_paddr = int'(req_addr_i); m_pwr = req_write_i; m_pdata = req_wdata_i;
    end
    m_busy = nbusy;
    if (mode_we_i) m_mode = mode_i;
    m_pc = (m_pc + 1) % DEPTH;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 direct_mode_o", 32'(direct_mode_o), 32'(m_mode));
    chk("R6 fetch_addr_o", 32'(fetch_addr_o), 32'(m_faddr()));
    chk("R7 fetch_instr_o", 32'(fetch_instr_o), 32'(m_mem[m_faddr()]));
    chk("R4 busy_o", 32'(busy_o), 32'(m_busy));
    chk("R9 err_o", 32'(err_o), 32'(m_err));
    chk("R8 rd_valid_o", 32'(rd_valid_o), 32'(m_rdv));
    chk("R8 rd_data_o", 32'(rd_data_o), 32'(m_rdd));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_req(input bit wr, input int a, input logic [DW-1:0] d);
    req_valid_i = 1; req_write_i = wr; req_addr_i = AW'(a); req_wdata_i = d;
    tick();
    req_valid_i = 0;
  endtask

  task automatic set_mode(input bit m);
    mode_we_i = 1; mode_i = m;
    tick();
    mode_we_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int tgt, cnt, prev;
    logic [DW-1:0] oldw;
    m_pc = 0; m_paddr = 0; m_mode = 1; m_busy = 0; m_err = 0; m_pwr = 0;
    m_rdv = 0; m_pdata = '0; m_rdd = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R2 / R1 reset state
    chk("R1 reset mode", 32'(direct_mode_o), 32'd1);
    chk("R2 reset busy", 32'(busy_o), 32'd0);
    chk("R2 reset err", 32'(err_o), 32'd0);
    chk("R2 reset rd_valid", 32'(rd_valid_o), 32'd0);
    chk("R2 reset fetch_addr", 32'(fetch_addr_o), 32'd0);
    chk("R2 reset word", 32'(fetch_instr_o), 32'd0);
    compare();

    // R3 stepping and wrap
    for (int i = 0; i < DEPTH + 4; i++) begin
      prev = int'(fetch_addr_o);
      tick();
      chk("R3 pc step", 32'(fetch_addr_o), 32'((prev + 1) % DEPTH));
    end

    // R5 direct write then read
    do_req(1, 5, 24'h0ABCDE);
    chk("R5 direct bus addr", 32'(fetch_addr_o), 32'd5);
    chk("R4 busy set", 32'(busy_o), 32'd1);
    tick();
    chk("R5 direct done", 32'(busy_o), 32'd0);
    do_req(0, 5, '0);
    tick();
    chk("R8 rd_valid", 32'(rd_valid_o), 32'd1);
    chk("R8 rd_data", 32'(rd_data_o), 32'h0ABCDE);
    tick();
    chk("R8 rd pulse ends", 32'(rd_valid_o), 32'd0);
    chk("R8 rd_data holds", 32'(rd_data_o), 32'h0ABCDE);

    // deferred mode
    set_mode(0);
    chk("R1 mode written", 32'(direct_mode_o), 32'd0);
    repeat (3) tick();

    // R6 R7 R10 worst-case deferred write
    tgt = int'(fetch_addr_o);
    oldw = m_mem[tgt];
    do_req(1, tgt, 24'h5A5A5A);
    cnt = 1;
    while (busy_o && cnt < 3 * DEPTH) begin
      if (int'(fetch_addr_o) == tgt)
        chk("R7 old word in slot", 32'(fetch_instr_o), 32'(oldw));
      tick();
      cnt++;
    end
    chk("R10 deferred bound", 32'(cnt <= DEPTH + 1), 32'd1);
    for (int i = 0; i < DEPTH && int'(fetch_addr_o) != tgt; i++) tick();
    chk("R7 new word next pass", 32'(fetch_instr_o), 32'h5A5A5A);

    // R9 request while busy dropped
    do_req(0, tgt, '0);
    do_req(1, (tgt + 7) % DEPTH, 24'h111111);
    chk("R9 err set", 32'(err_o), 32'd1);
    for (int i = 0; i < 2 * DEPTH && !rd_valid_o; i++) tick();
    chk("R9 first access kept", 32'(rd_data_o), 32'h5A5A5A);
    repeat (DEPTH + 2) tick();
    chk("R9 err sticky", 32'(err_o), 32'd1);

    // deferred write, then switch to direct while pending
    do_req(1, (int'(fetch_addr_o) + DEPTH - 2) % DEPTH, 24'h00C0DE);
    tick();
    set_mode(1);
    repeat (4) tick();
    chk("R5 finishes after mode switch", 32'(busy_o), 32'd0);
    repeat (DEPTH + 2) tick();
    finish_run();
  end
endmodule